// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache that sits between a processor-side word port and a simple main-memory port. Every line holds a valid flag, a stored tag and a block of four 32-bit words. A request splits the 32-bit byte address into tag, line index, word select and a byte offset that is ignored. A read that hits returns its word on the next cycle. A read that misses stalls the processor while the whole block is fetched from memory. Every write is sent on to memory. A write that misses first fetches the whole block, puts the new word into it, and then sends the word to memory.

The processor request channel uses valid/ready. A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. The requester must hold the request stable while ready is low. Ready drops in the cycle after a request that misses or writes, and it rises again in the cycle the response is presented. The response channel has no ready input: `cpu_rsp_valid` is a single-cycle pulse, and the requester must take the word in that cycle. The cache drives memory timing itself. After one address cycle, each word access takes a fixed number of access cycles and then one transfer cycle. The transfer cycle is marked by a one-cycle `mem_rd` or `mem_wr` strobe, and `mem_rdata` is sampled in that cycle.

Top module: `wt_dm_cache`

## Requirements
- R1: The byte address splits into a byte offset in bits [1:0], which is ignored, a word select in bits [3:2], a line index in the next INDEX_W bits (bits [15:4] by default, 4096 lines), and a tag in the remaining upper bits. Requests that differ only in bits [1:0] behave identically.
- R2: After reset every line is invalid, ready is high and no memory strobe is active. The first access to any line misses, and no initialisation cycles are visible.
- R3: A request hits only when its line's valid flag is set and the stored tag equals the address tag. A request to a valid line holding a different tag misses and replaces that line.
- R4: A read hit places the requested word on `cpu_rsp_rdata`, with `cpu_rsp_valid` high, in the cycle after acceptance. Ready stays high throughout and memory is not touched.
- R5: A read miss fetches all four words of the block in ascending word order. With default timing, `mem_rd` pulses in the 17th, 33rd, 49th and 65th cycles after acceptance. The response appears in the 66th cycle and carries the requested word from memory.
- R6: After a refill, the block's valid flag and tag are set, so reads of any word in that block hit.
- R7: A write hit updates the word in the cache and issues exactly one `mem_wr` carrying the word address and data. With default timing, `mem_wr` pulses in the 17th cycle after acceptance and the response appears in the 18th.
- R8: A write miss performs the four-word refill, replaces the addressed word with the write data, installs the block, and then issues one `mem_wr`. With default timing, `mem_wr` pulses in the 82nd cycle and the response appears in the 83rd.
- R9: From the cycle after a miss or write is accepted until its response, `cpu_req_ready` is low and `cpu_rsp_valid` is low. Ready is high in the response cycle.
- R10: `mem_rd` and `mem_wr` are single-cycle pulses, never active together, and never active while ready is high. A refill issues exactly four reads and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Request present |
| cpu_req_ready | output | 1 | Cache can take a request this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 32 | Write word |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read word (write data echoed for writes) |
| mem_rd | output | 1 | Word read transfer strobe |
| mem_wr | output | 1 | Word write transfer strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, sampled while `mem_rd` is high |

## Verification
The bench runs the cache with 16 lines against a memory model and keeps its own expected memory and line-state table. It first sweeps cold reads over every line. It then sweeps every word and every byte offset of the filled lines; this separates correct field slicing from wrong slicing and tells hits from refills by latency alone. Same-index conflicting tags show whether the tag compare and the replacement work. Write hits and write misses, followed by reads of the neighbouring words, show whether the merged word lands in the right slot. Re-reading after an eviction proves that memory received the written word. A long pseudo-random mix over four tags then checks each access's data, its latency, and the count, cycle and address of every strobe it causes.

// File: rtl/wt_dm_cache_pkg.sv
package wt_dm_cache_pkg;
  localparam int unsigned BYTE_OFF_W = 2;
  localparam int unsigned WORD_W     = 32;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_FILL  = 2'd1,
    CS_WRITE = 2'd2
  } cache_state_e;
endpackage

// File: rtl/wt_dm_memseq.sv
// Fixed-latency memory sequencer: one address phase, then per word an
// access phase followed by a transfer phase ending in a strobe.
module wt_dm_memseq
  import wt_dm_cache_pkg::*;
#(
  parameter int unsigned LINE_AW    = 28,
  parameter int unsigned OFFSET_W   = 2,
  parameter int unsigned ADDR_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 15,
  parameter int unsigned XFER_CYC   = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic                               block_i,
  input  logic [LINE_AW-1:0]                 line_i,
  input  logic [OFFSET_W-1:0]                word_i,
  output logic                               mem_rd_o,
  output logic                               mem_wr_o,
  output logic [LINE_AW+OFFSET_W+BYTE_OFF_W-1:0] mem_addr_o,
  output logic [OFFSET_W-1:0]                beat_o,
  output logic                               done_o
);
  localparam int unsigned BEAT_PERIOD = ACCESS_CYC + XFER_CYC;
  localparam int unsigned CNT_MAX     = (BEAT_PERIOD > ADDR_CYC) ? BEAT_PERIOD : ADDR_CYC;
  localparam int unsigned CNT_W       = $clog2(CNT_MAX) + 1;
  localparam logic [CNT_W-1:0]    ADDR_LAST = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0]    BEAT_LAST = CNT_W'(BEAT_PERIOD - 1);
  localparam logic [OFFSET_W-1:0] LAST_WORD = '1;

  logic                active_q;
  logic                in_addr_q;
  logic                block_q;
  logic [CNT_W-1:0]    sub_q;
  logic [OFFSET_W-1:0] beat_q;
  logic [OFFSET_W-1:0] word_q;
  logic [LINE_AW-1:0]  line_q;
  logic                strobe;
  logic                final_beat;

  assign strobe     = active_q && !in_addr_q && (sub_q == BEAT_LAST);
  assign final_beat = block_q ? (beat_q == LAST_WORD) : 1'b1;
  assign done_o     = strobe && final_beat;
  assign mem_rd_o   = strobe && block_q;
  assign mem_wr_o   = strobe && !block_q;
  assign beat_o     = beat_q;
  assign mem_addr_o = {line_q, (block_q ? beat_q : word_q), {BYTE_OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      in_addr_q <= 1'b0;
      block_q   <= 1'b0;
      sub_q     <= '0;
      beat_q    <= '0;
      word_q    <= '0;
      line_q    <= '0;
    end else if (start_i) begin
      active_q  <= 1'b1;
      in_addr_q <= 1'b1;
      block_q   <= block_i;
      sub_q     <= '0;
      beat_q    <= '0;
      word_q    <= word_i;
      line_q    <= line_i;
    end else if (active_q) begin
      if (in_addr_q) begin
        if (sub_q == ADDR_LAST) begin
          in_addr_q <= 1'b0;
          sub_q     <= '0;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else if (strobe) begin
        sub_q <= '0;
        if (final_beat) active_q <= 1'b0;
        else            beat_q   <= beat_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wt_dm_tagstore.sv
// Valid flags (reset in one cycle) and tags, with combinational compare.
module wt_dm_tagstore #(
  parameter int unsigned INDEX_W = 12,
  parameter int unsigned TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0]   rd_tag_i,
  output logic               hit_o,
  input  logic               wr_en_i,
  input  logic [INDEX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i
);
  localparam int unsigned LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  assign hit_o = valid_q[rd_idx_i] && (tag_mem[rd_idx_i] == rd_tag_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) tag_mem[wr_idx_i] <= wr_tag_i;
  end
endmodule

// File: rtl/wt_dm_datastore.sv
// Block data, one array per word lane; whole-line or single-word write.
module wt_dm_datastore
  import wt_dm_cache_pkg::*;
#(
  parameter int unsigned INDEX_W  = 12,
  parameter int unsigned OFFSET_W = 2
) (
  input  logic                                   clk,
  input  logic [INDEX_W-1:0]                     rd_idx_i,
  output logic [(1<<OFFSET_W)-1:0][WORD_W-1:0]   rd_line_o,
  input  logic                                   line_we_i,
  input  logic                                   word_we_i,
  input  logic [INDEX_W-1:0]                     wr_idx_i,
  input  logic [OFFSET_W-1:0]                    wr_sel_i,
  input  logic [(1<<OFFSET_W)-1:0][WORD_W-1:0]   line_i,
  input  logic [WORD_W-1:0]                      word_i
);
  localparam int unsigned LINES = 1 << INDEX_W;
  localparam int unsigned WORDS = 1 << OFFSET_W;

  for (genvar k = 0; k < WORDS; k++) begin : g_lane
    logic [WORD_W-1:0] lane_mem [LINES];
    logic              lane_we;
    logic [WORD_W-1:0] lane_wd;

    assign lane_we = line_we_i || (word_we_i && (wr_sel_i == OFFSET_W'(k)));
    assign lane_wd = line_we_i ? line_i[k] : word_i;
    assign rd_line_o[k] = lane_mem[rd_idx_i];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[wr_idx_i] <= lane_wd;
    end
  end
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache
  import wt_dm_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INDEX_W    = 12,
  parameter int unsigned OFFSET_W   = 2,
  parameter int unsigned ADDR_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 15,
  parameter int unsigned XFER_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [31:0]       cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rsp_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int unsigned WORDS   = 1 << OFFSET_W;
  localparam int unsigned WSEL_LSB = BYTE_OFF_W;
  localparam int unsigned IDX_LSB = BYTE_OFF_W + OFFSET_W;
  localparam int unsigned TAG_LSB = IDX_LSB + INDEX_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
  localparam int unsigned LINE_AW = ADDR_W - IDX_LSB;

  typedef logic [WORDS-1:0][WORD_W-1:0] line_t;

  cache_state_e        state_q;
  logic                rq_we;
  logic [ADDR_W-1:0]   rq_addr;
  logic [WORD_W-1:0]   rq_wdata;
  line_t               fill_q;
  line_t               fill_line;
  line_t               rd_line;
  logic [WORD_W-1:0]   in_word;

  logic                accept;
  logic                hit;
  logic                seq_start;
  logic                seq_block;
  logic                seq_done;
  logic [OFFSET_W-1:0] seq_beat;
  logic [LINE_AW-1:0]  seq_line;
  logic [OFFSET_W-1:0] seq_word;
  logic                tag_we;
  logic                line_we;
  logic                word_we;

  logic [INDEX_W-1:0]  cpu_idx;
  logic [TAG_W-1:0]    cpu_tag;
  logic [OFFSET_W-1:0] cpu_wsel;
  logic [INDEX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]    rq_tag;
  logic [OFFSET_W-1:0] rq_wsel;

  assign cpu_idx  = cpu_req_addr[TAG_LSB-1:IDX_LSB];
  assign cpu_tag  = cpu_req_addr[ADDR_W-1:TAG_LSB];
  assign cpu_wsel = cpu_req_addr[IDX_LSB-1:WSEL_LSB];
  assign rq_idx   = rq_addr[TAG_LSB-1:IDX_LSB];
  assign rq_tag   = rq_addr[ADDR_W-1:TAG_LSB];
  assign rq_wsel  = rq_addr[IDX_LSB-1:WSEL_LSB];

  assign cpu_req_ready = (state_q == CS_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign mem_wdata     = rq_wdata;

  wt_dm_tagstore #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_i (cpu_idx),
    .rd_tag_i (cpu_tag),
    .hit_o    (hit),
    .wr_en_i  (tag_we),
    .wr_idx_i (rq_idx),
    .wr_tag_i (rq_tag)
  );

  wt_dm_datastore #(.INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W)) u_data (
    .clk       (clk),
    .rd_idx_i  (cpu_idx),
    .rd_line_o (rd_line),
    .line_we_i (line_we),
    .word_we_i (word_we),
    .wr_idx_i  (rq_idx),
    .wr_sel_i  (rq_wsel),
    .line_i    (fill_line),
    .word_i    (rq_wdata)
  );

  wt_dm_memseq #(
    .LINE_AW(LINE_AW), .OFFSET_W(OFFSET_W), .ADDR_CYC(ADDR_CYC),
    .ACCESS_CYC(ACCESS_CYC), .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (seq_start),
    .block_i    (seq_block),
    .line_i     (seq_line),
    .word_i     (seq_word),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr),
    .mem_addr_o (mem_addr),
    .beat_o     (seq_beat),
    .done_o     (seq_done)
  );

  // Incoming beat, with the pending write word merged into its slot.
  assign in_word = (rq_we && (seq_beat == rq_wsel)) ? rq_wdata : mem_rdata;

  always_comb begin
    fill_line           = fill_q;
    fill_line[seq_beat] = in_word;
  end

  always_comb begin
    seq_line = (state_q == CS_IDLE) ? cpu_req_addr[ADDR_W-1:IDX_LSB] : rq_addr[ADDR_W-1:IDX_LSB];
    seq_word = (state_q == CS_IDLE) ? cpu_wsel : rq_wsel;
  end

  always_comb begin
    seq_start = 1'b0;
    seq_block = 1'b0;
    tag_we    = 1'b0;
    line_we   = 1'b0;
    word_we   = 1'b0;
    unique case (state_q)
      CS_IDLE: begin
        if (accept && !(hit && !cpu_req_we)) begin
          seq_start = 1'b1;
          seq_block = !hit;
        end
      end
      CS_FILL: begin
        if (seq_done) begin
          tag_we  = 1'b1;
          line_we = 1'b1;
          if (rq_we) seq_start = 1'b1;
        end
      end
      CS_WRITE: begin
        if (seq_done) word_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= CS_IDLE;
      rq_we         <= 1'b0;
      rq_addr       <= '0;
      rq_wdata      <= '0;
      fill_q        <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      unique case (state_q)
        CS_IDLE: begin
          if (accept) begin
            rq_we    <= cpu_req_we;
            rq_addr  <= cpu_req_addr;
            rq_wdata <= cpu_req_wdata;
            if (hit && !cpu_req_we) begin
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_rdata <= rd_line[cpu_wsel];
            end else begin
              state_q <= hit ? CS_WRITE : CS_FILL;
            end
          end
        end
        CS_FILL: begin
          if (mem_rd) fill_q[seq_beat] <= in_word;
          if (seq_done) begin
            if (rq_we) begin
              state_q <= CS_WRITE;
            end else begin
              state_q       <= CS_IDLE;
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_rdata <= fill_line[rq_wsel];
            end
          end
        end
        CS_WRITE: begin
          if (seq_done) begin
            state_q       <= CS_IDLE;
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= rq_wdata;
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_dm_cache_chk.sv
module wt_dm_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_req_valid,
  input logic cpu_req_ready,
  input logic cpu_rsp_valid,
  input logic mem_rd,
  input logic mem_wr
);
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_MEM_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> (!mem_rd && !mem_wr)); // R10

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R10

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr); // R10

  AST_STALL_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req_ready |-> !cpu_rsp_valid); // R9

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> (cpu_rsp_valid || !cpu_req_ready)); // R4

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_req_ready) |-> $past(cpu_req_valid)); // R9
endmodule

bind wt_dm_cache wt_dm_cache_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr)
);

// File: tb/sim_wt_dm_cache.sv
`timescale 1ns/1ps
module sim_wt_dm_cache;
  localparam int IDXW = 4;
  localparam int LINES = 1 << IDXW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] phys_mem [1024];
  logic [31:0] exp_mem  [1024];
  bit          exp_valid [LINES];
  logic [23:0] exp_tag   [LINES];

  always #10 clk = ~clk;

  wt_dm_cache #(.INDEX_W(IDXW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_valid), .cpu_req_ready(req_ready), .cpu_req_we(req_we),
    .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(rsp_valid), .cpu_rsp_rdata(rsp_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = phys_mem[mem_addr[11:2]];
  always @(posedge clk) if (mem_wr) phys_mem[mem_addr[11:2]] <= mem_wdata;

  function automatic logic [31:0] init_word(int i);
    return 32'hC0DE_0000 ^ (i * 32'h0001_0193);
  endfunction

  function automatic logic [31:0] mk(int tag, int idx, int w, int b);
    return (tag << 8) | (idx << 4) | (w << 2) | b;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One access; checks latency, stall, strobes and data against the model.
  task automatic access(bit we, logic [31:0] a, logic [31:0] d);
    int idx = int'(a[7:4]);
    logic [23:0] tg = a[31:8];
    bit hit = exp_valid[idx] && (exp_tag[idx] == tg);
    int exp_lat = we ? (hit ? 18 : 83) : (hit ? 1 : 66);
    logic [31:0] exp_rd = exp_mem[a[11:2]];
    int n = 0;
    int rdcnt = 0;
    int wrcnt = 0;
    bit stall_ok = 1'b1;
    string rq = we ? (hit ? "R7" : "R8") : (hit ? "R4" : "R5");
    @(negedge clk);
    chk(req_ready, "R9", 32'(req_ready), 1, "ready before request");
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (mem_rd) begin
        chk(n == 17 + 16 * rdcnt, "R10", 32'(n), 32'(17 + 16 * rdcnt), "mem_rd cycle");
        chk(mem_addr == ((a & ~32'hF) | (rdcnt << 2)), "R5", mem_addr,
            (a & ~32'hF) | (rdcnt << 2), "beat address");
        rdcnt++;
      end
      if (mem_wr) begin
        chk(n == (hit ? 17 : 82), rq, 32'(n), hit ? 17 : 82, "mem_wr cycle");
        chk(mem_addr == (a & ~32'h3), rq, mem_addr, a & ~32'h3, "mem_wr address");
        chk(mem_wdata == d, rq, mem_wdata, d, "mem_wr data");
        wrcnt++;
      end
      if (rsp_valid) break;
      if (req_ready) stall_ok = 1'b0;
      if (n > 300) break;
    end
    chk(n == exp_lat, rq, 32'(n), 32'(exp_lat), "response latency");
    chk(stall_ok, "R9", 32'(stall_ok), 1, "ready low while stalled");
    chk(req_ready, "R9", 32'(req_ready), 1, "ready in response cycle");
    chk(rdcnt == (hit ? 0 : 4), "R10", 32'(rdcnt), hit ? 0 : 4, "read strobes");
    chk(wrcnt == (we ? 1 : 0), "R10", 32'(wrcnt), we ? 1 : 0, "write strobes");
    if (!we) chk(rsp_rdata == exp_rd, rq, rsp_rdata, exp_rd, "read data");
    if (!hit) begin exp_valid[idx] = 1'b1; exp_tag[idx] = tg; end
    if (we) exp_mem[a[11:2]] = d;
    @(negedge clk);
    chk(!rsp_valid, "R9", 32'(rsp_valid), 0, "response single pulse");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      phys_mem[i] = init_word(i);
      exp_mem[i]  = init_word(i);
    end
    for (int i = 0; i < LINES; i++) begin exp_valid[i] = 1'b0; exp_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(req_ready, "R2", 32'(req_ready), 1, "ready after reset");
    chk(!rsp_valid, "R2", 32'(rsp_valid), 0, "rsp after reset");
    chk(!mem_rd && !mem_wr, "R2", 32'({mem_rd, mem_wr}), 0, "mem idle after reset");
    // R2/R5: cold sweep, every line misses once
    for (int i = 0; i < LINES; i++) access(1'b0, mk(1, i, i % 4, 0), 0);
    // R1/R6: every word and byte offset of filled lines hits
    for (int i = 0; i < LINES; i++)
      for (int w = 0; w < 4; w++)
        for (int b = 0; b < 4; b++) access(1'b0, mk(1, i, w, b), 0);
    // R3: conflicting tag on same index misses and replaces
    access(1'b0, mk(2, 3, 0, 0), 0);
    access(1'b0, mk(1, 3, 1, 0), 0);
    access(1'b0, mk(2, 3, 2, 0), 0);
    access(1'b0, mk(2, 3, 2, 1), 0);
    // R7: write hit then read back
    access(1'b1, mk(2, 3, 1, 0), 32'hA5A5_1111);
    access(1'b0, mk(2, 3, 1, 2), 0);
    // R8: write miss then read all words of the merged block
    access(1'b1, mk(5, 7, 2, 0), 32'h5EED_2222);
    for (int w = 0; w < 4; w++) access(1'b0, mk(5, 7, w, 0), 0);
    // R8: evict and refetch, memory must hold the written word
    access(1'b0, mk(1, 7, 0, 0), 0);
    access(1'b0, mk(5, 7, 2, 3), 0);
    access(1'b0, mk(2, 3, 1, 0), 0);
    // R1..R10 mixed pseudo-random sweep over four tags
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        access(lf[0] & lf[5], mk(int'(lf[3:2]), int'(lf[9:6]), int'(lf[11:10]), int'(lf[13:12])),
               {lf, ~lf});
      end
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule